// File: doc/BRIEF.md
# Configuration Store Protection Controller

This block sits in front of a small configuration store and decides, one command at a time, whether an access may go ahead. Two protection flags, one against readback and one against modification, give four protection settings. A caller pulses a command strobe with an opcode, an address and write data. Exactly one cycle later the block answers with a one-cycle grant or a one-cycle deny pulse. A granted command takes effect on the same clock edge that raises the grant.

The readback lock hides the stored pattern and also refuses programming. It still permits a full erase, and a full erase is the only way to clear it. The modification lock refuses both erase and programming, and its own clear command turns it off. A synchronous reset stands for power-up. It loads both flags from two non-volatile preset inputs and empties the store.

Commands are plain strobes with no back-pressure. A strobe is taken in every cycle in which it is high, so back-to-back commands are allowed and each one gets its own answer. Read data and the two flag states are plain outputs.

Top module: `cfg_guard_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_lock` equals `preset_rd_lock`, `wr_lock` equals `preset_wr_lock`, `grant`, `deny` and `rd_data` are 0, and every store word reads 0 once a read is granted.
- R2: A strobe in cycle n gives exactly one of `grant` or `deny` high in cycle n+1, for that cycle only. A cycle without a strobe is followed by a cycle with neither.
- R3: Read (opcode 0) is granted exactly when `rd_lock` is 0. A granted read returns the word at `cmd_addr` on `rd_data` in the grant cycle. In every other cycle `rd_data` is 0.
- R4: Program (opcode 1) is granted exactly when both flags are 0. It overwrites the addressed word with `cmd_wdata`. A denied program leaves the store unchanged.
- R5: Full erase (opcode 2) is granted exactly when `wr_lock` is 0. It sets every word to 0 and clears `rd_lock`, and leaves `wr_lock` unchanged.
- R6: An erase denied because `wr_lock` is 1 leaves every word and `rd_lock` unchanged.
- R7: Set-readback-lock (opcode 3) is granted exactly when `wr_lock` is 0 and sets `rd_lock`. No other command sets `rd_lock`.
- R8: Set-modification-lock (opcode 4) is granted exactly when `wr_lock` is 0 and sets `wr_lock`. Clear-modification-lock (opcode 5) is always granted and clears only `wr_lock`.
- R9: With both flags at 1, every opcode except 5 is denied.
- R10: Opcodes 6 and 7 are always denied and change neither the flags nor the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (power-up) |
| preset_rd_lock | input | 1 | Non-volatile power-up value of the readback lock |
| preset_wr_lock | input | 1 | Non-volatile power-up value of the modification lock |
| cmd_strobe | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (0 read, 1 program, 2 erase, 3 set readback lock, 4 set modification lock, 5 clear modification lock) |
| cmd_addr | input | ADDR_W | Word address for read and program |
| cmd_wdata | input | DATA_W | Program data |
| grant | output | 1 | Command accepted, one cycle after the strobe |
| deny | output | 1 | Command refused, one cycle after the strobe |
| rd_data | output | DATA_W | Read result in the grant cycle of a read, else 0 |
| rd_lock | output | 1 | Readback lock state |
| wr_lock | output | 1 | Modification lock state |

## Verification
The bench builds the block with ADDR_W=2 and DATA_W=8. With only four words it can read back every word after an erase or a refused erase, so it confirms that the whole store was cleared or left intact. It visits all four flag combinations through commands and also enters the locked-both state through the preset inputs. The 8-bit data width lets each word carry a distinct pattern, so a write to the wrong address is caught.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam logic [2:0] OP_READ      = 3'd0;
  localparam logic [2:0] OP_PROG      = 3'd1;
  localparam logic [2:0] OP_ERASE     = 3'd2;
  localparam logic [2:0] OP_LOCK_RD   = 3'd3;
  localparam logic [2:0] OP_LOCK_WR   = 3'd4;
  localparam logic [2:0] OP_UNLOCK_WR = 3'd5;

  typedef struct packed {
    logic valid;
    logic grant;
    logic do_read;
    logic do_prog;
    logic do_erase;
    logic set_rd;
    logic set_wr;
    logic clr_wr;
  } decision_t;
endpackage

// File: rtl/cfg_guard_policy.sv
module cfg_guard_policy
  import cfg_guard_pkg::*;
(
  input  logic       strobe,
  input  logic [2:0] op,
  input  logic       rd_lock,
  input  logic       wr_lock,
  output decision_t  dec
);
  logic allowed;

  always_comb begin
    unique case (op)
      OP_READ:      allowed = !rd_lock;
      OP_PROG:      allowed = !rd_lock && !wr_lock;
      OP_ERASE:     allowed = !wr_lock;
      OP_LOCK_RD:   allowed = !wr_lock;
      OP_LOCK_WR:   allowed = !wr_lock;
      OP_UNLOCK_WR: allowed = 1'b1;
      default:      allowed = 1'b0;
    endcase
  end

  always_comb begin
    dec          = '0;
    dec.valid    = strobe;
    dec.grant    = strobe && allowed;
    dec.do_read  = dec.grant && (op == OP_READ);
    dec.do_prog  = dec.grant && (op == OP_PROG);
    dec.do_erase = dec.grant && (op == OP_ERASE);
    dec.set_rd   = dec.grant && (op == OP_LOCK_RD);
    dec.set_wr   = dec.grant && (op == OP_LOCK_WR);
    dec.clr_wr   = dec.grant && (op == OP_UNLOCK_WR);
  end
endmodule

// File: rtl/cfg_guard_lockbits.sv
module cfg_guard_lockbits
  import cfg_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      preset_rd,
  input  logic      preset_wr,
  input  decision_t dec,
  output logic      rd_lock,
  output logic      wr_lock
);
  always_ff @(posedge clk) begin
    if (rst)               rd_lock <= preset_rd;
    else if (dec.set_rd)   rd_lock <= 1'b1;
    else if (dec.do_erase) rd_lock <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)             wr_lock <= preset_wr;
    else if (dec.set_wr) wr_lock <= 1'b1;
    else if (dec.clr_wr) wr_lock <= 1'b0;
  end

  AST_RDLOCK_SET_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_lock) |-> $past(dec.set_rd)); // R7
  AST_RDLOCK_CLEAR_ONLY_BY_ERASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_lock) |-> $past(dec.do_erase)); // R5
  AST_WRLOCK_CLEAR_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_lock) |-> $past(dec.clr_wr)); // R8
  AST_ERASE_KEEPS_WRLOCK: assert property (@(posedge clk) disable iff (rst)
    dec.do_erase |=> $stable(wr_lock)); // R5
endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  word_nz;
  logic              any_nz;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || erase)
        words[i] <= '0;
      else if (wr_en && (addr == ADDR_W'(i)))
        words[i] <= wdata;
    end
    assign word_nz[i] = |words[i];
  end

  assign rdata  = words[addr];
  assign any_nz = |word_nz;

  AST_ERASE_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
    erase |=> !any_nz); // R5
  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !erase) |=> $stable(word_nz)); // R4
endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_rd_lock,
  input  logic              preset_wr_lock,
  input  logic              cmd_strobe,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              grant,
  output logic              deny,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_lock,
  output logic              wr_lock
);
  decision_t         dec;
  logic [DATA_W-1:0] store_rdata;

  cfg_guard_policy u_policy (
    .strobe  (cmd_strobe),
    .op      (cmd_op),
    .rd_lock (rd_lock),
    .wr_lock (wr_lock),
    .dec     (dec)
  );

  cfg_guard_lockbits u_locks (
    .clk       (clk),
    .rst       (rst),
    .preset_rd (preset_rd_lock),
    .preset_wr (preset_wr_lock),
    .dec       (dec),
    .rd_lock   (rd_lock),
    .wr_lock   (wr_lock)
  );

  cfg_guard_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (dec.do_prog),
    .erase (dec.do_erase),
    .addr  (cmd_addr),
    .wdata (cmd_wdata),
    .rdata (store_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= 1'b0;
      deny    <= 1'b0;
      rd_data <= '0;
    end else begin
      grant   <= dec.grant;
      deny    <= dec.valid && !dec.grant;
      rd_data <= dec.do_read ? store_rdata : '0;
    end
  end

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny)); // R2
  AST_RESPONSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> (grant || deny)); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_strobe |=> !(grant || deny)); // R2
  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_op == OP_READ && rd_lock) |=> deny); // R3
  AST_RDATA_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    !grant |-> (rd_data == '0)); // R3
  AST_BOTH_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && rd_lock && wr_lock && cmd_op != OP_UNLOCK_WR) |=> deny); // R9
  AST_UNKNOWN_OP_DENIED: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_op > OP_UNLOCK_WR) |=> (deny && $stable(rd_lock) && $stable(wr_lock))); // R10
endmodule

// File: tb/cfg_guard_top_tb.sv
module cfg_guard_top_tb;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_rd = 1'b0, p_wr = 1'b0;
  logic cmd_strobe = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic grant, deny, rd_lock, wr_lock;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  cfg_guard_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .preset_rd_lock(p_rd), .preset_wr_lock(p_wr),
    .cmd_strobe(cmd_strobe), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .grant(grant), .deny(deny), .rd_data(rd_data),
    .rd_lock(rd_lock), .wr_lock(wr_lock)
  );

  typedef struct {
    bit            g;
    logic [DW-1:0] d;
    int            due;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   m_rd, m_wr;
  logic [DW-1:0] m_mem [NW];

  always @(posedge clk) cyc++;

  // Monitor: pops the expected response due in this cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (grant || deny) begin
        if (q.size() == 0 || q[0].due != cyc) begin
          checks++; errors++;
          $display("FAIL R2: unexpected response grant=%0b deny=%0b, expected none", grant, deny);
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (grant != e.g || deny != !e.g || rd_data != e.d) begin
            errors++;
            $display("FAIL %s: grant=%0b deny=%0b data=%h, expected grant=%0b data=%h",
                     e.tag, grant, deny, rd_data, e.g, e.d);
          end
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++; errors++;
        $display("FAIL R2 (%s): no response, expected grant=%0b", e.tag, e.g);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input int a, input logic [DW-1:0] d, input string tag);
    exp_t e;
    bit g;
    case (op)
      3'd0: g = !m_rd;
      3'd1: g = !m_rd && !m_wr;
      3'd2: g = !m_wr;
      3'd3: g = !m_wr;
      3'd4: g = !m_wr;
      3'd5: g = 1'b1;
      default: g = 1'b0;
    endcase
    e.g = g; e.d = '0; e.tag = tag;
    if (g) begin
      case (op)
        3'd0: e.d = m_mem[a];
        3'd1: m_mem[a] = d;
        3'd2: begin for (int i = 0; i < NW; i++) m_mem[i] = '0; m_rd = 1'b0; end
        3'd3: m_rd = 1'b1;
        3'd4: m_wr = 1'b1;
        3'd5: m_wr = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_wdata = d;
    e.due = cyc + 1;
    q.push_back(e);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    cmd_strobe = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_locks(input bit er, input bit ew, input string tag);
    checks++;
    if (rd_lock != er || wr_lock != ew) begin
      errors++;
      $display("FAIL %s: rd_lock=%0b wr_lock=%0b, expected %0b %0b", tag, rd_lock, wr_lock, er, ew);
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NW; i++) issue(3'd0, i, '0, tag);
    idle_drain();
  endtask

  task automatic do_reset(input bit pr, input bit pw);
    cmd_strobe = 1'b0;
    rst = 1'b1; p_rd = pr; p_wr = pw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant || deny || rd_data != '0) begin
      errors++;
      $display("FAIL R1: grant=%0b deny=%0b data=%h in reset, expected 0 0 00", grant, deny, rd_data);
    end
    rst = 1'b0;
    m_rd = pr; m_wr = pw;
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    q.delete();
    @(negedge clk);
    check_locks(pr, pw, "R1 after reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    read_all("R1 store cleared");
    // R4 program distinct patterns, R3 readback, back-to-back strobes for R2
    issue(3'd1, 0, 8'hA5, "R4 program");
    issue(3'd1, 1, 8'h3C, "R4 program");
    issue(3'd1, 2, 8'hF0, "R4 program");
    issue(3'd1, 3, 8'h0F, "R4 program");
    idle_drain();
    read_all("R3 readback");
    // R10 unknown opcodes
    issue(3'd6, 1, 8'hFF, "R10 opcode 6");
    issue(3'd7, 2, 8'hFF, "R10 opcode 7");
    idle_drain();
    check_locks(1'b0, 1'b0, "R10 flags unchanged");
    read_all("R10 store unchanged");
    // R8 set modification lock, then R4/R6 refusals
    issue(3'd4, 0, '0, "R8 set wr");
    issue(3'd1, 0, 8'h11, "R4 program under wr");
    issue(3'd2, 0, '0, "R6 erase under wr");
    issue(3'd3, 0, '0, "R7 set rd under wr");
    issue(3'd4, 0, '0, "R8 set wr again");
    idle_drain();
    check_locks(1'b0, 1'b1, "R6 flags after refused erase");
    read_all("R6 store intact");
    // R8 clear, R7 set readback lock
    issue(3'd5, 0, '0, "R8 clear wr");
    issue(3'd3, 0, '0, "R7 set rd");
    issue(3'd0, 2, '0, "R3 read under rd");
    issue(3'd1, 2, 8'h22, "R4 program under rd");
    idle_drain();
    check_locks(1'b1, 1'b0, "R7 flags");
    // R9 both locks
    issue(3'd4, 0, '0, "R8 set wr with rd");
    for (int op = 0; op < 8; op++) begin
      if (op != 5) issue(3'(op), 1, 8'h55, "R9 both locked");
    end
    idle_drain();
    check_locks(1'b1, 1'b1, "R9 flags held");
    issue(3'd5, 0, '0, "R9 clear wr granted");
    issue(3'd2, 0, '0, "R5 erase with rd");
    idle_drain();
    check_locks(1'b0, 1'b0, "R5 erase clears rd only");
    read_all("R5 store erased");
    issue(3'd1, 3, 8'h77, "R4 program after erase");
    issue(3'd0, 3, '0, "R3 read after erase");
    idle_drain();
    // R1 preset power-up state
    do_reset(1'b1, 1'b1);
    issue(3'd0, 0, '0, "R1 preset read denied");
    issue(3'd2, 0, '0, "R9 preset erase denied");
    idle_drain();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule